// File: doc/BRIEF.md
# Dual-Width Hash Message Padding Generator

This block produces the trailer that closes a message for a Merkle-Damgard hash core. It has two block sizes. Narrow mode uses 64-byte blocks, as SHA-1 and SHA-256 do. Wide mode uses 128-byte blocks, as SHA-384 and SHA-512 do. While a message streams elsewhere, each update reports its size in bytes. The block adds that size into a 128-bit byte count, which is held as two 64-bit words, and a carry from the low word moves into the high word.

At finalisation a start pulse captures two things: the block-size mode and the number of residual bytes that are already buffered. The block then streams the pad out one byte per accepted cycle using a valid/ready handshake. The stream is a single 0x80 marker, then zero bytes up to the length boundary of the current block, then the message bit count in big-endian order. It also presents the total number of appended bytes, so that message plus pad ends on a block boundary. When the final byte is accepted, the count is cleared for the next message.

The controller is a four-state machine:
- IDLE accepts updates and start.
- MARK emits 0x80.
- ZERO emits the fill.
- LEN emits the length field.

Transitions:
- IDLE→MARK on an accepted start.
- MARK→ZERO when fill bytes remain.
- MARK→LEN when the pad before the field is one byte.
- ZERO→LEN after the last fill byte.
- LEN→IDLE after the final field byte.

Top module: `mdpad_gen`

## Requirements
- R1: After reset, pad_valid is 0, upd_ready is 1, pad_total is 0 and the byte count is zero.
- R2: Each accepted update adds upd_size to the low 64-bit word of the count; a wrap of the low word increments the high word.
- R3: upd_ready is 0 while a pad is being emitted and in any cycle where start is high; a refused update leaves the count unchanged.
- R4: start is honoured only in IDLE, latching wide_mode (0 = 64-byte blocks, 1 = 128-byte blocks) and resid; a start during emission has no effect on the stream.
- R5: The first pad byte is 0x80; every other byte before the length field is 0x00.
- R6: In narrow mode, with idx = resid mod 64, the bytes before the length field number 56 − idx when idx < 56, otherwise 120 − idx.
- R7: In wide mode, with idx = resid mod 128, the bytes before the length field number 112 − idx when idx < 112, otherwise 240 − idx.
- R8: In narrow mode the length field is 8 bytes: the low word shifted left by 3, most significant byte first.
- R9: In wide mode the length field is 16 bytes: first the high word shifted left by 3 ORed with the top 3 bits of the low word, then the low word shifted left by 3, each most significant byte first.
- R10: From the cycle after an accepted start, pad_total equals the pre-field pad length plus 8 (narrow) or 16 (wide), and holds until the next accepted start.
- R11: While pad_valid is high and pad_ready low, pad_byte and pad_last hold; pad_last is high only on the final length byte.
- R12: Once the final byte is accepted, the block returns to IDLE with the count cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | An update of upd_size bytes is offered |
| upd_size | input | SIZE_W | Byte size of the offered update |
| upd_ready | output | 1 | Update is accepted this cycle |
| start | input | 1 | Finalise request |
| wide_mode | input | 1 | 0: 64-byte blocks, 1: 128-byte blocks |
| resid | input | RES_W | Residual buffered byte count at finalisation |
| pad_valid | output | 1 | pad_byte carries a pad byte |
| pad_ready | input | 1 | Consumer takes the pad byte |
| pad_byte | output | 8 | Current pad byte |
| pad_last | output | 1 | Current byte is the final length byte |
| pad_total | output | CNT_W | Total appended bytes of the latest pad |

## Verification
The assertions assume that pad_ready may toggle freely, but that start, resid and wide_mode are meaningful only in IDLE. They also assume that update sizes fit in SIZE_W bits. The stimulus drives every input at the falling edge and leaves it stable across the rising edge. It offers updates and starts while the block is busy only to show that they are refused. It brings the low word to the brink of wrapping with a single large update, instead of relying on any hidden preload.

// File: rtl/mdpad_pkg.sv
package mdpad_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MARK,
        ST_ZERO,
        ST_LEN
    } pad_state_e;

    localparam logic [7:0] MARKER_BYTE = 8'h80;
    localparam logic [7:0] FILL_BYTE   = 8'h00;
endpackage

// File: rtl/mdpad_counter.sv
module mdpad_counter #(
    parameter int SIZE_W = 64,
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en,
    input  logic [SIZE_W-1:0] add_size,
    input  logic              clr,
    output logic [WORD_W-1:0] cnt_lo,
    output logic [WORD_W-1:0] cnt_hi
);
    localparam int PAD_W = WORD_W + 1 - SIZE_W;

    logic [WORD_W:0] sum;

    assign sum = {1'b0, cnt_lo} + {{PAD_W{1'b0}}, add_size};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else if (add_en) begin
            cnt_lo <= sum[WORD_W-1:0];
            if (sum[WORD_W]) begin
                cnt_hi <= cnt_hi + WORD_W'(1);
            end
        end
    end
endmodule

// File: rtl/mdpad_geom.sv
module mdpad_geom #(
    parameter int RES_W  = 8,
    parameter int CNT_W  = 8,
    parameter int WORD_W = 64
) (
    input  logic             wide,
    input  logic [RES_W-1:0] resid,
    output logic [CNT_W-1:0] pad_len,
    output logic [CNT_W-1:0] field_len,
    output logic [CNT_W-1:0] total_len
);
    localparam int NARROW_BLK = 64;
    localparam int WIDE_BLK   = 128;
    localparam int NARROW_FLD = WORD_W / 8;
    localparam int WIDE_FLD   = 2 * WORD_W / 8;
    localparam int NARROW_BND = NARROW_BLK - NARROW_FLD;
    localparam int WIDE_BND   = WIDE_BLK - WIDE_FLD;

    logic [RES_W-1:0] idx_r;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] bound;
    logic [CNT_W-1:0] span;

    always_comb begin
        if (wide) begin
            idx_r     = resid & RES_W'(WIDE_BLK - 1);
            bound     = CNT_W'(WIDE_BND);
            span      = CNT_W'(WIDE_BLK);
            field_len = CNT_W'(WIDE_FLD);
        end else begin
            idx_r     = resid & RES_W'(NARROW_BLK - 1);
            bound     = CNT_W'(NARROW_BND);
            span      = CNT_W'(NARROW_BLK);
            field_len = CNT_W'(NARROW_FLD);
        end
        idx = CNT_W'(idx_r);
        if (idx < bound) begin
            pad_len = bound - idx;
        end else begin
            pad_len = span + bound - idx;
        end
        total_len = pad_len + field_len;
    end
endmodule

// File: rtl/mdpad_gen.sv
module mdpad_gen
    import mdpad_pkg::*;
#(
    parameter int SIZE_W = 64,
    parameter int RES_W  = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [SIZE_W-1:0] upd_size,
    output logic              upd_ready,
    input  logic              start,
    input  logic              wide_mode,
    input  logic [RES_W-1:0]  resid,
    output logic              pad_valid,
    input  logic              pad_ready,
    output logic [7:0]        pad_byte,
    output logic              pad_last,
    output logic [CNT_W-1:0]  pad_total
);
    localparam int WORD_W  = 64;
    localparam int FIELD_W = 2 * WORD_W;

    pad_state_e st_q, st_d;
    logic [CNT_W-1:0]   left_q, left_d;
    logic [CNT_W-1:0]   total_d;
    logic [FIELD_W-1:0] field_q, field_d;
    logic               wide_q, wide_d;

    logic [WORD_W-1:0] cnt_lo, cnt_hi;
    logic [WORD_W-1:0] bits_lo, bits_hi;
    logic [CNT_W-1:0]  geo_pad, geo_field, geo_total;
    logic [CNT_W-1:0]  run_field;
    logic [CNT_W-1:0]  unused_field;
    logic              start_ok, fire, cnt_clr;

    assign start_ok  = start && (st_q == ST_IDLE);
    assign upd_ready = (st_q == ST_IDLE) && !start;
    assign fire      = pad_valid && pad_ready;
    assign bits_lo   = cnt_lo << 3;
    assign bits_hi   = (cnt_hi << 3) | (cnt_lo >> (WORD_W - 3));

    mdpad_counter #(.SIZE_W(SIZE_W), .WORD_W(WORD_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en   (upd_valid && upd_ready),
        .add_size (upd_size),
        .clr      (cnt_clr),
        .cnt_lo   (cnt_lo),
        .cnt_hi   (cnt_hi)
    );

    mdpad_geom #(.RES_W(RES_W), .CNT_W(CNT_W), .WORD_W(WORD_W)) u_geom (
        .wide      (wide_mode),
        .resid     (resid),
        .pad_len   (geo_pad),
        .field_len (geo_field),
        .total_len (geo_total)
    );

    mdpad_geom #(.RES_W(RES_W), .CNT_W(CNT_W), .WORD_W(WORD_W)) u_fld (
        .wide      (wide_q),
        .resid     ('0),
        .pad_len   (unused_field),
        .field_len (run_field),
        .total_len ()
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            left_q    <= '0;
            field_q   <= '0;
            wide_q    <= 1'b0;
            pad_total <= '0;
        end else begin
            st_q      <= st_d;
            left_q    <= left_d;
            field_q   <= field_d;
            wide_q    <= wide_d;
            pad_total <= total_d;
        end
    end

    always_comb begin
        st_d    = st_q;
        left_d  = left_q;
        field_d = field_q;
        wide_d  = wide_q;
        total_d = pad_total;
        cnt_clr = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_ok) begin
                    st_d    = ST_MARK;
                    left_d  = geo_pad;
                    total_d = geo_total;
                    wide_d  = wide_mode;
                    field_d = wide_mode ? {bits_hi, bits_lo}
                                        : {bits_lo, {WORD_W{1'b0}}};
                end
            end
            ST_MARK: begin
                if (fire) begin
                    if (left_q == CNT_W'(1)) begin
                        st_d   = ST_LEN;
                        left_d = run_field;
                    end else begin
                        st_d   = ST_ZERO;
                        left_d = left_q - CNT_W'(1);
                    end
                end
            end
            ST_ZERO: begin
                if (fire) begin
                    if (left_q == CNT_W'(1)) begin
                        st_d   = ST_LEN;
                        left_d = run_field;
                    end else begin
                        left_d = left_q - CNT_W'(1);
                    end
                end
            end
            ST_LEN: begin
                if (fire) begin
                    field_d = field_q << 8;
                    if (left_q == CNT_W'(1)) begin
                        st_d    = ST_IDLE;
                        left_d  = '0;
                        cnt_clr = 1'b1;
                    end else begin
                        left_d = left_q - CNT_W'(1);
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pad_valid = 1'b0;
        pad_byte  = FILL_BYTE;
        pad_last  = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_MARK: begin
                pad_valid = 1'b1;
                pad_byte  = MARKER_BYTE;
            end
            ST_ZERO: begin
                pad_valid = 1'b1;
            end
            ST_LEN: begin
                pad_valid = 1'b1;
                pad_byte  = field_q[FIELD_W-1 -: 8];
                pad_last  = (left_q == CNT_W'(1));
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mdpad_gen_chk.sv
module mdpad_gen_chk #(
    parameter int RES_W = 8,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             upd_ready,
    input logic             start,
    input logic             wide_mode,
    input logic [RES_W-1:0] resid,
    input logic             pad_valid,
    input logic             pad_ready,
    input logic [7:0]       pad_byte,
    input logic             pad_last,
    input logic [CNT_W-1:0] pad_total
);
    logic [RES_W-1:0] res_q;
    logic             wide_q;
    logic [CNT_W:0]   sum;
    logic             aligned;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            wide_q <= 1'b0;
        end else begin
            res_q  <= resid;
            wide_q <= wide_mode;
        end
    end

    assign sum     = {1'b0, pad_total} + (CNT_W + 1)'(res_q);
    assign aligned = wide_q ? (sum[6:0] == 7'd0) : (sum[5:0] == 6'd0);

    assert_busy_refuses_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pad_valid |-> !upd_ready);

    assert_marker_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !pad_valid) |=> (pad_valid && pad_byte == 8'h80));

    assert_total_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !pad_valid) |=> aligned);

    assert_hold_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_valid && !pad_ready) |=> (pad_valid && $stable(pad_byte) && $stable(pad_last)));

    assert_last_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pad_last |-> pad_valid);

    assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_valid && pad_ready && pad_last) |=> (!pad_valid && upd_ready == !start));
endmodule

bind mdpad_gen mdpad_gen_chk #(.RES_W(RES_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_ready (upd_ready),
    .start     (start),
    .wide_mode (wide_mode),
    .resid     (resid),
    .pad_valid (pad_valid),
    .pad_ready (pad_ready),
    .pad_byte  (pad_byte),
    .pad_last  (pad_last),
    .pad_total (pad_total)
);

// File: tb/tb_mdpad_gen.sv
module tb_mdpad_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid = 1'b0;
    logic [63:0] upd_size = '0;
    logic        upd_ready;
    logic        start = 1'b0;
    logic        wide_mode = 1'b0;
    logic [7:0]  resid = '0;
    logic        pad_valid;
    logic        pad_ready = 1'b0;
    logic [7:0]  pad_byte;
    logic        pad_last;
    logic [7:0]  pad_total;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    bit [127:0] m_cnt = '0;
    byte unsigned m_q[$];
    string m_tag[$];
    int m_total = 0;

    always #2 clk = ~clk;

    mdpad_gen dut (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_size(upd_size),
        .upd_ready(upd_ready), .start(start), .wide_mode(wide_mode), .resid(resid),
        .pad_valid(pad_valid), .pad_ready(pad_ready), .pad_byte(pad_byte),
        .pad_last(pad_last), .pad_total(pad_total)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic build(input bit wm, input int res);
        int idx, bnd, span, plen, flen;
        bit [127:0] bits;
        idx  = wm ? res % 128 : res % 64;
        bnd  = wm ? 112 : 56;
        span = wm ? 128 : 64;
        flen = wm ? 16 : 8;
        plen = (idx < bnd) ? bnd - idx : span + bnd - idx;
        bits = m_cnt << 3;
        m_q.push_back(8'h80);
        m_tag.push_back("R5");
        for (int i = 1; i < plen; i++) begin
            m_q.push_back(8'h00);
            m_tag.push_back(wm ? "R7" : "R6");
        end
        for (int i = flen - 1; i >= 0; i--) begin
            m_q.push_back(bits[i*8 +: 8]);
            m_tag.push_back(wm ? "R9 R2" : "R8 R2");
        end
        m_total = plen + flen;
    endtask

    task automatic tick(input bit v, input longint unsigned sz, input bit st,
                        input bit wm, input int res, input bit rdy);
        bit idle;
        upd_valid = v; upd_size = sz; start = st; wide_mode = wm;
        resid = 8'(res); pad_ready = rdy;
        #1;
        idle = (m_q.size() == 0);
        check(upd_ready == (idle && !st), "R3 upd_ready", longint'(upd_ready), longint'(idle && !st));
        if (idle) begin
            if (st) build(wm, res);
            else if (v) m_cnt += 128'(sz);
        end else if (rdy) begin
            void'(m_q.pop_front());
            void'(m_tag.pop_front());
            if (m_q.size() == 0) m_cnt = '0;
        end
        @(negedge clk);
        check(pad_valid == (m_q.size() != 0), "R11 valid", longint'(pad_valid), longint'(m_q.size() != 0));
        if (m_q.size() != 0) begin
            check(pad_byte == m_q[0], m_tag[0], longint'(pad_byte), longint'(m_q[0]));
            check(pad_last == (m_q.size() == 1), "R11 last", longint'(pad_last), longint'(m_q.size() == 1));
        end
        check(int'(pad_total) == m_total, "R10 total", longint'(pad_total), longint'(m_total));
    endtask

    task automatic drain(input int pat);
        int n = 0;
        while (m_q.size() != 0) begin
            // R4: stray start and update while busy must be ignored
            tick(n % 5 == 2, 64'd7, n % 7 == 3, ~wide_mode, 3, (pat == 0) || (n % pat != 0));
            n++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(pad_valid == 1'b0, "R1 valid", longint'(pad_valid), 0);
        check(pad_total == 8'd0, "R1 total", longint'(pad_total), 0);
        #1;
        check(upd_ready == 1'b1, "R1 ready", longint'(upd_ready), 1);
        // narrow, idx 40
        tick(1, 64'd3, 0, 0, 0, 1);
        tick(1, 64'd100, 0, 0, 0, 1);
        tick(1, 64'd9, 1, 0, 40, 1);   // R3: update refused with start
        drain(0);
        // R12: count cleared; narrow idx 56 with stalls
        tick(1, 64'd1000, 0, 0, 0, 0);
        tick(0, 64'd0, 1, 0, 56, 0);
        drain(3);
        // R2 carry into high word, wide idx 0
        tick(1, 64'hFFFF_FFFF_FFFF_FFFB, 0, 1, 0, 1);
        tick(1, 64'd10, 0, 1, 0, 1);
        tick(0, 64'd0, 1, 1, 0, 1);
        drain(2);
        // wide idx 120
        tick(1, 64'h2000_0000_0000_0001, 0, 1, 0, 1);
        tick(0, 64'd0, 1, 1, 120, 1);
        drain(4);
        // narrow idx 55 (single marker byte) and idx 63 via 255
        tick(1, 64'd55, 0, 0, 0, 1);
        tick(0, 64'd0, 1, 0, 55, 1);
        drain(0);
        tick(0, 64'd0, 1, 0, 255, 1);
        drain(2);
        // empty message, wide idx 0
        tick(0, 64'd0, 1, 1, 0, 1);
        drain(0);
        tick(0, 64'd0, 0, 0, 0, 1);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule